// File: doc/BRIEF.md
# Interleaved Flash Command Formatter

This block prepares one command cycle for a parallel NOR flash bus that may be made of several identical devices wired side by side. Given an 8-bit command code and a command offset in device words, it produces the data word to drive on the bus, with the command copied into every device's lane, and the byte address to drive. Where a device wider than its lane is run in its narrow mode, unlock offsets get an extra low address bit. The same block folds a wide status word read back from the bus into one device-sized status value. Any device that reports a status bit makes that bit show in the folded value.

The geometry is given with each request: bus width in bytes, number of interleaved devices, and device width in bytes. The lane width, or chip mode, is the bus width divided by the interleave. A request is taken when `reqValid` is high. The results appear on registered outputs one cycle later, flagged by `outValid`, and they hold until the next request. A geometry with no legal lane width sets a sticky error flag, and the outputs of that request are zero. Lanes are little-endian.

Top module: `cmdfmt_top`

## Requirements
- R1: For a request, `cmdAddr` equals `cmdOffset` × `devBytes` × `interleave`, except for the case in R2.
- R2: When `devBytes` × `interleave` is greater than `busBytes` and `cmdOffset[7:0]` is 8'hAA, the value (`devBytes`/2) × `interleave` is ORed into the address of R1.
- R3: A geometry is legal only when `busBytes` is 1, 2, 4 or 8 and not above MAX_BUS_BYTES, `interleave` is 1, 2, 4 or 8, `devBytes` is 1, 2 or 4, and `busBytes`/`interleave` is 1, 2 or 4.
- R4: On a legal request, `cmdData` holds `cmdCode`, zero-extended to the lane width, in each of the `interleave` lanes. Lane k occupies bits starting at k × lane width × 8, and all bits at or above `busBytes` × 8 are zero.
- R5: On a legal request, `statusMerged` is the bitwise OR of the `interleave` lanes of `statusWord`, placed in its low lane-width bytes, with all higher bits zero. Bits of `statusWord` at or above `busBytes` × 8 have no effect.
- R6: A request with an illegal geometry drives `cmdData`, `cmdAddr` and `statusMerged` to zero and sets `cfgError`. `cfgError` then stays high until reset, and later legal requests are still formatted normally.
- R7: `outValid` is high in exactly the cycle after a cycle with `reqValid` high, and the results of that request are on the outputs in that same cycle.
- R8: While `reqValid` is low, the input values have no effect and the data outputs keep the results of the last request.
- R9: After reset, `outValid`, `cfgError`, `cmdData`, `cmdAddr` and `statusMerged` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe; samples all other inputs |
| cmdCode | input | 8 | Command code for one device |
| cmdOffset | input | OFS_W (16) | Command offset in device words |
| busBytes | input | GEO_W (4) | Bus width in bytes |
| interleave | input | GEO_W (4) | Number of devices side by side |
| devBytes | input | GEO_W (4) | Width of one device in bytes |
| statusWord | input | MAX_BUS_BYTES*8 (64) | Raw status read from the bus |
| outValid | output | 1 | Results of the previous-cycle request are present |
| cmdData | output | MAX_BUS_BYTES*8 (64) | Replicated command data word |
| cmdAddr | output | ADDR_W (32) | Byte address for the command cycle |
| statusMerged | output | 32 | Status folded to one device's lane |
| cfgError | output | 1 | Sticky flag for an illegal geometry |

## Verification
On every cycle, the assertions check the request-to-valid timing, that outputs hold between requests, that the error flag is sticky, that an error request zeroes the outputs, and that the low lane carries the command. They also check two identities: a zero offset gives a zero address, and a zero status gives a zero merge. The exact lane replication for each chip mode and interleave, the fold of status across all lanes, and the compatibility address bit are shown only by the bench's vector table. The same holds for the legality boundaries and the clearing of the error flag by reset.

// File: rtl/cmdfmt_pkg.sv
package cmdfmt_pkg;

  // Strobes and decoded geometry passed from control to datapath
  typedef struct packed {
    logic       load;     // capture a new result this cycle
    logic       zeroOut;  // geometry illegal: capture zeros
    logic [1:0] laneLog2; // log2 of lane width in bytes
    logic [1:0] ilvLog2;  // log2 of interleave
    logic [1:0] devLog2;  // log2 of device width in bytes
    logic [1:0] busLog2;  // log2 of bus width in bytes
  } fmtCtrl_t;

  // Returns {isPowerOfTwoUpTo8, log2} for a small geometry count
  function automatic logic [2:0] pow2Code(input logic [3:0] v);
    logic [2:0] r;
    case (v)
      4'd1:    r = {1'b1, 2'd0};
      4'd2:    r = {1'b1, 2'd1};
      4'd4:    r = {1'b1, 2'd2};
      4'd8:    r = {1'b1, 2'd3};
      default: r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmdfmt_ctrl.sv
module cmdfmt_ctrl
  import cmdfmt_pkg::*;
#(
  parameter int GEO_W         = 4,
  parameter int MAX_BUS_BYTES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [GEO_W-1:0] busBytes,
  input  logic [GEO_W-1:0] interleave,
  input  logic [GEO_W-1:0] devBytes,
  output fmtCtrl_t         ctrl,
  output logic             outValid,
  output logic             cfgError
);

  localparam int MAX_BUS_LOG2 = $clog2(MAX_BUS_BYTES);

  logic [2:0] busCode, ilvCode, devCode;
  logic       busOk, ilvOk, devOk, laneOk, legal;
  logic [1:0] laneLog2;

  always_comb begin
    busCode = pow2Code(busBytes[3:0]);
    ilvCode = pow2Code(interleave[3:0]);
    devCode = pow2Code(devBytes[3:0]);
    busOk   = busCode[2] && (int'(busCode[1:0]) <= MAX_BUS_LOG2);
    ilvOk   = ilvCode[2];
    devOk   = devCode[2] && (devCode[1:0] != 2'd3);
    laneOk  = (busCode[1:0] >= ilvCode[1:0]) &&
              ((busCode[1:0] - ilvCode[1:0]) <= 2'd2);
    legal   = busOk && ilvOk && devOk && laneOk;
    laneLog2 = legal ? (busCode[1:0] - ilvCode[1:0]) : 2'd0;
  end

  always_comb begin
    ctrl.load     = reqValid;
    ctrl.zeroOut  = !legal;
    ctrl.laneLog2 = laneLog2;
    ctrl.ilvLog2  = ilvCode[1:0];
    ctrl.devLog2  = devCode[1:0];
    ctrl.busLog2  = busCode[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid && !legal) cfgError <= 1'b1;
    end
  end

endmodule

// File: rtl/cmdfmt_datapath.sv
module cmdfmt_datapath
  import cmdfmt_pkg::*;
#(
  parameter int OFS_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int MAX_BUS_BYTES = 8,
  parameter int STAT_W        = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fmtCtrl_t                     ctrl,
  input  logic [7:0]                   cmdCode,
  input  logic [OFS_W-1:0]             cmdOffset,
  input  logic [MAX_BUS_BYTES*8-1:0]   statusWord,
  output logic [MAX_BUS_BYTES*8-1:0]   cmdData,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic [STAT_W-1:0]            statusMerged
);

  localparam int DATA_W = MAX_BUS_BYTES * 8;
  localparam int STAGES = $clog2(MAX_BUS_BYTES);

  logic [DATA_W-1:0] busMask, repWord, foldWord;
  logic [STAT_W-1:0] laneMask, statNext;
  logic [ADDR_W-1:0] addrNext;
  int                laneBits, busBits, scale;
  logic              compatHit;

  // Masks for the active bus width and one lane
  always_comb begin
    laneBits = 8 << ctrl.laneLog2;
    busBits  = 8 << ctrl.busLog2;
    for (int i = 0; i < DATA_W; i++) busMask[i] = (i < busBits);
    for (int i = 0; i < STAT_W; i++) laneMask[i] = (i < laneBits);
  end

  // Command replication: widest step first, each step doubling the copies
  always_comb begin
    repWord = {{(DATA_W-8){1'b0}}, cmdCode};
    for (int s = STAGES - 1; s >= 0; s--) begin
      if (s < int'(ctrl.ilvLog2)) repWord = repWord | (repWord << (laneBits << s));
    end
    repWord = repWord & busMask;
  end

  // Status fold: widest step first, halving the span each time
  always_comb begin
    foldWord = statusWord & busMask;
    for (int s = STAGES - 1; s >= 0; s--) begin
      if (s < int'(ctrl.ilvLog2)) foldWord = foldWord | (foldWord >> (laneBits << s));
    end
    statNext = foldWord[STAT_W-1:0] & laneMask;
  end

  // Address scaling and narrow-mode unlock bit
  always_comb begin
    scale     = int'(ctrl.devLog2) + int'(ctrl.ilvLog2);
    addrNext  = ADDR_W'(cmdOffset) << scale;
    compatHit = (scale > int'(ctrl.busLog2)) && (cmdOffset[7:0] == 8'hAA) &&
                (ctrl.devLog2 != 2'd0);
    if (compatHit) addrNext = addrNext | (ADDR_W'(1) << (scale - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdData      <= '0;
      cmdAddr      <= '0;
      statusMerged <= '0;
    end else if (ctrl.load) begin
      if (ctrl.zeroOut) begin
        cmdData      <= '0;
        cmdAddr      <= '0;
        statusMerged <= '0;
      end else begin
        cmdData      <= repWord;
        cmdAddr      <= addrNext;
        statusMerged <= statNext;
      end
    end
  end

endmodule

// File: rtl/cmdfmt_top.sv
module cmdfmt_top
  import cmdfmt_pkg::*;
#(
  parameter int OFS_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int GEO_W         = 4,
  parameter int MAX_BUS_BYTES = 8,
  parameter int STAT_W        = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [7:0]                 cmdCode,
  input  logic [OFS_W-1:0]           cmdOffset,
  input  logic [GEO_W-1:0]           busBytes,
  input  logic [GEO_W-1:0]           interleave,
  input  logic [GEO_W-1:0]           devBytes,
  input  logic [MAX_BUS_BYTES*8-1:0] statusWord,
  output logic                       outValid,
  output logic [MAX_BUS_BYTES*8-1:0] cmdData,
  output logic [ADDR_W-1:0]          cmdAddr,
  output logic [STAT_W-1:0]          statusMerged,
  output logic                       cfgError
);

  fmtCtrl_t ctrl;

  cmdfmt_ctrl #(
    .GEO_W(GEO_W), .MAX_BUS_BYTES(MAX_BUS_BYTES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busBytes(busBytes), .interleave(interleave), .devBytes(devBytes),
    .ctrl(ctrl), .outValid(outValid), .cfgError(cfgError)
  );

  cmdfmt_datapath #(
    .OFS_W(OFS_W), .ADDR_W(ADDR_W), .MAX_BUS_BYTES(MAX_BUS_BYTES), .STAT_W(STAT_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cmdCode(cmdCode),
    .cmdOffset(cmdOffset), .statusWord(statusWord),
    .cmdData(cmdData), .cmdAddr(cmdAddr), .statusMerged(statusMerged)
  );

endmodule

// File: rtl/cmdfmt_checker.sv
module cmdfmt_checker #(
  parameter int OFS_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int MAX_BUS_BYTES = 8,
  parameter int STAT_W        = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic [7:0]                 cmdCode,
  input logic [OFS_W-1:0]           cmdOffset,
  input logic [MAX_BUS_BYTES*8-1:0] statusWord,
  input logic                       outValid,
  input logic [MAX_BUS_BYTES*8-1:0] cmdData,
  input logic [ADDR_W-1:0]          cmdAddr,
  input logic [STAT_W-1:0]          statusMerged,
  input logic                       cfgError
);

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(cmdData) && $stable(cmdAddr) && $stable(statusMerged)));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgError) |-> (cmdData == '0 && cmdAddr == '0 && statusMerged == '0));

  p_low_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgError) |=> (cfgError || cmdData[7:0] == $past(cmdCode)));

  p_zero_ofs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cmdOffset == '0) |=> (cmdAddr == '0));

  p_zero_stat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && statusWord == '0) |=> (statusMerged == '0));

endmodule

bind cmdfmt_top cmdfmt_checker #(
  .OFS_W(OFS_W), .ADDR_W(ADDR_W), .MAX_BUS_BYTES(MAX_BUS_BYTES), .STAT_W(STAT_W)
) i_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmdCode(cmdCode),
  .cmdOffset(cmdOffset), .statusWord(statusWord), .outValid(outValid),
  .cmdData(cmdData), .cmdAddr(cmdAddr), .statusMerged(statusMerged),
  .cfgError(cfgError)
);

// File: tb/test_cmdfmt_top.sv
`timescale 1ns/1ps
module test_cmdfmt_top;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [15:0] ofs;
    logic [3:0]  bus;
    logic [3:0]  ilv;
    logic [3:0]  dev;
    logic [63:0] stat;
    logic [63:0] eData;
    logic [31:0] eAddr;
    logic [31:0] eStat;
    logic        eErr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 R4 R5: x8 single device, status bits above bus ignored
    '{8'h98, 16'h0055, 4'd1, 4'd1, 4'd1, 64'hFFFF_FFFF_FFFF_FF80, 64'h98, 32'h55, 32'h80, 1'b0},
    // R1 R5: x16 native
    '{8'h98, 16'h0055, 4'd2, 4'd1, 4'd2, 64'hAAAA_0000_0000_1234, 64'h98, 32'hAA, 32'h1234, 1'b0},
    // R2: narrow mode, offset low byte not AA
    '{8'hAA, 16'h0555, 4'd1, 4'd1, 4'd2, 64'h0101, 64'hAA, 32'hAAA, 32'h01, 1'b0},
    // R2: narrow mode unlock offset
    '{8'h55, 16'h02AA, 4'd1, 4'd1, 4'd2, 64'h0, 64'h55, 32'h555, 32'h0, 1'b0},
    // R4 R5: two x16 devices on 32-bit bus
    '{8'h98, 16'h0055, 4'd4, 4'd2, 4'd2, 64'h0000_0000_0040_0001, 64'h0098_0098, 32'h154, 32'h0041, 1'b0},
    // R4 R5: eight x8 devices
    '{8'hF0, 16'h0010, 4'd8, 4'd8, 4'd1, 64'h0102_0408_1020_4080, 64'hF0F0_F0F0_F0F0_F0F0, 32'h80, 32'hFF, 1'b0},
    // R2 R4: two x16 devices in x8 mode
    '{8'h90, 16'h00AA, 4'd2, 4'd2, 4'd2, 64'hFFFF_0000_0000_8000, 64'h9090, 32'h2AA, 32'h80, 1'b0},
    // R5: x32 single device
    '{8'h98, 16'h0055, 4'd4, 4'd1, 4'd4, 64'h1111_1111_DEAD_BEEF, 64'h98, 32'h154, 32'hDEAD_BEEF, 1'b0},
    // R1 R5: four x8 devices, AA offset without narrow mode
    '{8'h70, 16'h00AA, 4'd4, 4'd4, 4'd1, 64'h0100_0000, 64'h7070_7070, 32'h2A8, 32'h01, 1'b0},
    // R2: x32 device in x16 mode
    '{8'h55, 16'h02AA, 4'd2, 4'd1, 4'd4, 64'h0300, 64'h55, 32'hAAA, 32'h0300, 1'b0},
    // R3 R6: lane width below one byte
    '{8'h98, 16'h0055, 4'd4, 4'd8, 4'd1, 64'hFF, 64'h0, 32'h0, 32'h0, 1'b1},
    // R3 R6: lane width of eight bytes
    '{8'h98, 16'h0055, 4'd8, 4'd1, 4'd1, 64'hFF, 64'h0, 32'h0, 32'h0, 1'b1},
    // R3 R6: bus width not a power of two
    '{8'h98, 16'h0055, 4'd3, 4'd1, 4'd1, 64'hFF, 64'h0, 32'h0, 32'h0, 1'b1},
    // R3 R6: device width of three bytes
    '{8'h98, 16'h0055, 4'd2, 4'd1, 4'd3, 64'hFF, 64'h0, 32'h0, 32'h0, 1'b1},
    // R6: legal request after error formats normally, flag stays
    '{8'h98, 16'h0055, 4'd1, 4'd1, 4'd1, 64'h80, 64'h98, 32'h55, 32'h80, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  cmdCode = '0;
  logic [15:0] cmdOffset = '0;
  logic [3:0]  busBytes = 4'd1, interleave = 4'd1, devBytes = 4'd1;
  logic [63:0] statusWord = '0;
  logic        outValid;
  logic [63:0] cmdData;
  logic [31:0] cmdAddr;
  logic [31:0] statusMerged;
  logic        cfgError;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmdfmt_top i_cmdfmt_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmdCode(cmdCode),
    .cmdOffset(cmdOffset), .busBytes(busBytes), .interleave(interleave),
    .devBytes(devBytes), .statusWord(statusWord), .outValid(outValid),
    .cmdData(cmdData), .cmdAddr(cmdAddr), .statusMerged(statusMerged),
    .cfgError(cfgError)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample one cycle later
  task automatic applyVec(input vec_t v, input int idx);
    @(negedge clk);
    reqValid = 1'b1; cmdCode = v.cmd; cmdOffset = v.ofs;
    busBytes = v.bus; interleave = v.ilv; devBytes = v.dev; statusWord = v.stat;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7", $sformatf("vec%0d outValid", idx), 64'(outValid), 64'd1);
    check("R4", $sformatf("vec%0d cmdData", idx), cmdData, v.eData);
    check("R1/R2", $sformatf("vec%0d cmdAddr", idx), 64'(cmdAddr), 64'(v.eAddr));
    check("R5", $sformatf("vec%0d statusMerged", idx), 64'(statusMerged), 64'(v.eStat));
    check("R6", $sformatf("vec%0d cfgError", idx), 64'(cfgError), 64'(v.eErr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "outValid", 64'(outValid), 64'd0);
    check("R9", "cmdData", cmdData, 64'd0);
    check("R9", "cmdAddr", 64'(cmdAddr), 64'd0);
    check("R9", "statusMerged", 64'(statusMerged), 64'd0);
    check("R9", "cfgError", 64'(cfgError), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) applyVec(VECS[i], i);

    // R8: idle cycles with changed inputs leave outputs unchanged
    @(negedge clk);
    cmdCode = 8'h11; cmdOffset = 16'h1234; busBytes = 4'd4; interleave = 4'd4;
    devBytes = 4'd1; statusWord = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R7", "outValid low when idle", 64'(outValid), 64'd0);
    check("R8", "cmdData held", cmdData, 64'h98);
    check("R8", "cmdAddr held", 64'(cmdAddr), 64'h55);
    check("R8", "statusMerged held", 64'(statusMerged), 64'h80);

    // R6 R9: reset clears the sticky flag, legal request keeps it low
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9", "cfgError after reset", 64'(cfgError), 64'd0);
    check("R9", "cmdData after reset", cmdData, 64'd0);
    rstN = 1'b1;
    applyVec(VECS[4], 4);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule